// File: doc/BRIEF.md
# Robbed-Bit Signalling Extractor

This block sits on the system side of a T1 receive path. It sees the serial PCM stream one bit per clock, together with the bit's position: channel, bit inside the channel and frame inside the multiframe. In the signalling frames it takes the least significant bit of each of the 24 channels as a candidate A, B, C or D signalling bit. It keeps one candidate word, one previous-multiframe word and one held word per channel. At each multiframe end a channel's held word takes the new value only when the same word was seen in two multiframes in a row. This debounces one-off bit errors.

The held word of the channel now on the line is driven on four signalling outputs for the whole channel time. Two strobes come with it: one marks the LSB bit time, for reinserting the bits, and one rises at every channel start, for serial-to-parallel conversion. Updates are blocked while a slip is reported or while the inhibit input is low. After inhibit is released, a selectable number of further multiframes stays blocked. A freeze flag shows when updates are disabled. A one-cycle multiframe pulse marks the instant at which updates take effect.

Top module: `rb_sig_extract`

## Requirements
- R1: `bit8_o` is high in the cycle after a step with `bit_vld`=1 and `bit_idx`=7, and low after every other step.
- R2: `chan_clk_o` is high in the cycle after a valid step with `bit_idx` 0..3 and low otherwise, so it rises once at every channel start.
- R3: With `ext_mf`=0 (12 frames, `frame_idx` 0..11), the LSB at frame index 5 becomes signalling bits A and C, and the LSB at frame index 11 becomes B and D.
- R4: With `ext_mf`=1 (24 frames, `frame_idx` 0..23), the LSBs at frame indices 5, 11, 17 and 23 become A, B, C and D.
- R5: Update happens at the multiframe end step (last frame, channel 23, `bit_idx` 7, valid). A channel's held word changes there only if the word captured in this multiframe equals the word captured in the previous one. A value seen once, or values that alternate, leave the held word unchanged.
- R6: `slip_in` high at a multiframe end blocks that update, and `freeze_o` is high in the cycle after any step with `slip_in` high.
- R7: `inhibit_n` low at a multiframe end blocks that update, and `freeze_o` is high in the cycle after any step with `inhibit_n` low.
- R8: After `inhibit_n` returns high, `hold_mode` 00, 01, 10 and 11 keep the next 0, 1, 2 and 4 multiframe ends blocked, and `freeze_o` stays high until the last of them has passed.
- R9: `mf_pulse_o` is high for one cycle, in the cycle after each multiframe end step, and low at all other times.
- R10: In the cycle after each step, `sig_a`..`sig_d` show the held word of that step's channel, so they stay constant for all 8 bits of that channel.
- R11: Reset clears all held words and drives every output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System-side bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_in | input | 1 | System-side serial PCM bit |
| bit_vld | input | 1 | High when the step carries a channel bit (low on the framing bit) |
| chan_idx | input | 5 | Channel of the current bit, 0..23 |
| bit_idx | input | 3 | Bit within the channel, 0 = MSB, 7 = LSB |
| frame_idx | input | 5 | Frame within the multiframe |
| slip_in | input | 1 | Slip in progress; blocks updates |
| inhibit_n | input | 1 | Low blocks signalling updates |
| hold_mode | input | 2 | Post-inhibit freeze length code |
| ext_mf | input | 1 | 0 = 12-frame multiframe, 1 = 24-frame multiframe |
| sig_a | output | 1 | Held A bit of the current channel |
| sig_b | output | 1 | Held B bit of the current channel |
| sig_c | output | 1 | Held C bit of the current channel |
| sig_d | output | 1 | Held D bit of the current channel |
| bit8_o | output | 1 | LSB bit-time strobe |
| chan_clk_o | output | 1 | Channel clock, rises at channel start |
| freeze_o | output | 1 | Updates currently disabled |
| mf_pulse_o | output | 1 | Multiframe update instant |

## Verification
The main function is driven with four stimulus patterns. A per-channel value held steady for three multiframes shows that an update needs two matching captures. Two values alternating in every multiframe show that no update happens without a repeat. A new value held steady while slip or inhibit is asserted shows that the block tells a blocked update from a late one, and the post-release timer is counted multiframe by multiframe. Both frame modes use distinct A/B per channel, and extended mode also uses distinct C/D, so a wrong frame-to-letter mapping or C/D copy shows up in the values.

// File: rtl/sig_pkg.sv
package sig_pkg;

    localparam int FW         = 5;
    localparam int D4_FRAMES  = 12;
    localparam int EXT_FRAMES = 24;
    localparam int SLOT_A     = 3;
    localparam int SLOT_B     = 2;
    localparam int SLOT_C     = 1;
    localparam int SLOT_D     = 0;

    typedef logic [3:0] abcd_t;

    // which signalling slot (0..3) a frame carries, 4 = none
    function automatic logic [2:0] sig_slot(input logic [FW-1:0] fr);
        case (fr)
            5'd5:    return 3'd0;
            5'd11:   return 3'd1;
            5'd17:   return 3'd2;
            5'd23:   return 3'd3;
            default: return 3'd4;
        endcase
    endfunction

    // letters written by a slot, bit SLOT_A..SLOT_D
    function automatic abcd_t slot_mask(input logic [2:0] slot, input logic ext);
        if (slot > 3'd3)
            return '0;
        if (ext)
            return abcd_t'(4'b1000 >> slot);
        case (slot)
            3'd0:    return 4'b1010;
            3'd1:    return 4'b0101;
            default: return 4'b0000;
        endcase
    endfunction

    // multiframes kept frozen after inhibit release
    function automatic logic [2:0] freeze_len(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd0;
            2'd1:    return 3'd1;
            2'd2:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/sig_timing.sv
module sig_timing
    import sig_pkg::*;
#(
    parameter int NUM_CH  = 24,
    parameter int CH_BITS = 8,
    localparam int CW     = $clog2(NUM_CH),
    localparam int BW     = $clog2(CH_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_vld,
    input  logic [CW-1:0] chan_idx,
    input  logic [BW-1:0] bit_idx,
    input  logic [FW-1:0] frame_idx,
    input  logic          ext_mf,
    output abcd_t         cap_mask,
    output logic          mf_end,
    output logic          bit8_o,
    output logic          chan_clk_o,
    output logic          mf_pulse_o
);

    typedef struct packed {
        logic bit8;
        logic chclk;
        logic mfp;
    } tim_t;

    tim_t s_d, s_q;
    logic in_range, lsb;
    logic [FW-1:0] last_fr;

    always_comb begin
        in_range = ({1'b0, chan_idx} < (CW+1)'(NUM_CH));
        lsb      = bit_vld && in_range && (bit_idx == BW'(CH_BITS-1));
        last_fr  = ext_mf ? FW'(EXT_FRAMES-1) : FW'(D4_FRAMES-1);
        mf_end   = lsb && (chan_idx == CW'(NUM_CH-1)) && (frame_idx == last_fr);
        cap_mask = lsb ? slot_mask(sig_slot(frame_idx), ext_mf) : '0;

        s_d       = s_q;
        s_d.bit8  = lsb;
        s_d.chclk = bit_vld && in_range && (bit_idx < BW'(CH_BITS/2));
        s_d.mfp   = mf_end;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bit8_o     = s_q.bit8;
    assign chan_clk_o = s_q.chclk;
    assign mf_pulse_o = s_q.mfp;

endmodule

// File: rtl/sig_freeze.sv
module sig_freeze
    import sig_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slip_in,
    input  logic       inhibit_n,
    input  logic [1:0] hold_mode,
    input  logic       mf_end,
    output logic       freeze_now,
    output logic       freeze_o
);

    typedef struct packed {
        logic [2:0] timer;
        logic       frz;
    } frz_t;

    frz_t s_d, s_q;

    always_comb begin
        freeze_now = !inhibit_n || slip_in || (s_q.timer != 3'd0);
        s_d        = s_q;
        s_d.frz    = freeze_now;
        if (!inhibit_n)
            s_d.timer = freeze_len(hold_mode);
        else if (mf_end && (s_q.timer != 3'd0))
            s_d.timer = s_q.timer - 3'd1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign freeze_o = s_q.frz;

endmodule

// File: rtl/sig_store.sv
module sig_store
    import sig_pkg::*;
#(
    parameter int NUM_CH = 24,
    localparam int CW    = $clog2(NUM_CH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ser_in,
    input  logic [CW-1:0] chan_idx,
    input  abcd_t         cap_mask,
    input  logic          mf_end,
    input  logic          freeze_now,
    output abcd_t         sig_o
);

    typedef struct packed {
        logic [NUM_CH-1:0][3:0] cand;
        logic [NUM_CH-1:0][3:0] prev;
        logic [NUM_CH-1:0][3:0] held;
        abcd_t                  sig;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        // capture this step's LSB into the letters its frame carries
        for (int c = 0; c < NUM_CH; c++) begin
            if (chan_idx == CW'(c)) begin
                for (int j = 0; j < 4; j++) begin
                    if (cap_mask[j]) s_d.cand[c][j] = ser_in;
                end
            end
        end
        // two-multiframe integration at the multiframe end
        if (mf_end) begin
            for (int c = 0; c < NUM_CH; c++) begin
                s_d.prev[c] = s_d.cand[c];
                if (!freeze_now && (s_d.cand[c] == s_q.prev[c]))
                    s_d.held[c] = s_d.cand[c];
            end
        end
        // present the current channel's held word
        s_d.sig = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (chan_idx == CW'(c)) s_d.sig = s_q.held[c];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sig_o = s_q.sig;

endmodule

// File: rtl/rb_sig_extract.sv
module rb_sig_extract
    import sig_pkg::*;
#(
    parameter int NUM_CH  = 24,
    parameter int CH_BITS = 8,
    localparam int CW     = $clog2(NUM_CH),
    localparam int BW     = $clog2(CH_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ser_in,
    input  logic          bit_vld,
    input  logic [CW-1:0] chan_idx,
    input  logic [BW-1:0] bit_idx,
    input  logic [FW-1:0] frame_idx,
    input  logic          slip_in,
    input  logic          inhibit_n,
    input  logic [1:0]    hold_mode,
    input  logic          ext_mf,
    output logic          sig_a,
    output logic          sig_b,
    output logic          sig_c,
    output logic          sig_d,
    output logic          bit8_o,
    output logic          chan_clk_o,
    output logic          freeze_o,
    output logic          mf_pulse_o
);

    abcd_t cap_mask;
    abcd_t sig_w;
    logic  mf_end;
    logic  freeze_now;

    sig_timing #(.NUM_CH(NUM_CH), .CH_BITS(CH_BITS)) u_timing (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_vld    (bit_vld),
        .chan_idx   (chan_idx),
        .bit_idx    (bit_idx),
        .frame_idx  (frame_idx),
        .ext_mf     (ext_mf),
        .cap_mask   (cap_mask),
        .mf_end     (mf_end),
        .bit8_o     (bit8_o),
        .chan_clk_o (chan_clk_o),
        .mf_pulse_o (mf_pulse_o)
    );

    sig_freeze u_freeze (
        .clk        (clk),
        .rst_n      (rst_n),
        .slip_in    (slip_in),
        .inhibit_n  (inhibit_n),
        .hold_mode  (hold_mode),
        .mf_end     (mf_end),
        .freeze_now (freeze_now),
        .freeze_o   (freeze_o)
    );

    sig_store #(.NUM_CH(NUM_CH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_in     (ser_in),
        .chan_idx   (chan_idx),
        .cap_mask   (cap_mask),
        .mf_end     (mf_end),
        .freeze_now (freeze_now),
        .sig_o      (sig_w)
    );

    assign sig_a = sig_w[SLOT_A];
    assign sig_b = sig_w[SLOT_B];
    assign sig_c = sig_w[SLOT_C];
    assign sig_d = sig_w[SLOT_D];

endmodule

// File: rtl/rb_sig_chk.sv
module rb_sig_chk #(
    parameter int NUM_CH  = 24,
    parameter int CH_BITS = 8,
    localparam int CW     = $clog2(NUM_CH),
    localparam int BW     = $clog2(CH_BITS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bit_vld,
    input logic [CW-1:0] chan_idx,
    input logic [BW-1:0] bit_idx,
    input logic          slip_in,
    input logic          inhibit_n,
    input logic          sig_a,
    input logic          sig_b,
    input logic          sig_c,
    input logic          sig_d,
    input logic          bit8_o,
    input logic          chan_clk_o,
    input logic          freeze_o,
    input logic          mf_pulse_o
);

    assert_bit8_lsb_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bit8_o |-> $past(bit_vld && (bit_idx == BW'(CH_BITS-1))));

    assert_chclk_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chan_clk_o) |-> $past(bit_vld && (bit_idx == '0)));

    assert_freeze_slip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        slip_in |=> freeze_o);

    assert_freeze_inhibit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !inhibit_n |=> freeze_o);

    assert_mf_pulse_pos_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mf_pulse_o |-> $past(bit_vld && (chan_idx == CW'(NUM_CH-1))
                             && (bit_idx == BW'(CH_BITS-1))));

    assert_mf_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mf_pulse_o |=> !mf_pulse_o);

    assert_sig_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_idx == $past(chan_idx)) |=> $stable({sig_a, sig_b, sig_c, sig_d}));

endmodule

bind rb_sig_extract rb_sig_chk #(.NUM_CH(NUM_CH), .CH_BITS(CH_BITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_vld    (bit_vld),
    .chan_idx   (chan_idx),
    .bit_idx    (bit_idx),
    .slip_in    (slip_in),
    .inhibit_n  (inhibit_n),
    .sig_a      (sig_a),
    .sig_b      (sig_b),
    .sig_c      (sig_c),
    .sig_d      (sig_d),
    .bit8_o     (bit8_o),
    .chan_clk_o (chan_clk_o),
    .freeze_o   (freeze_o),
    .mf_pulse_o (mf_pulse_o)
);

// File: tb/sim_rb_sig_extract.sv
module sim_rb_sig_extract;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       ser_in = 1'b0, bit_vld = 1'b0;
    logic [4:0] chan_idx = '0;
    logic [2:0] bit_idx = '0;
    logic [4:0] frame_idx = '0;
    logic       slip_in = 1'b0, inhibit_n = 1'b1, ext_mf = 1'b0;
    logic [1:0] hold_mode = 2'd0;
    logic       sig_a, sig_b, sig_c, sig_d, bit8_o, chan_clk_o, freeze_o, mf_pulse_o;

    rb_sig_extract u0 (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .bit_vld(bit_vld),
        .chan_idx(chan_idx), .bit_idx(bit_idx), .frame_idx(frame_idx),
        .slip_in(slip_in), .inhibit_n(inhibit_n), .hold_mode(hold_mode),
        .ext_mf(ext_mf), .sig_a(sig_a), .sig_b(sig_b), .sig_c(sig_c),
        .sig_d(sig_d), .bit8_o(bit8_o), .chan_clk_o(chan_clk_o),
        .freeze_o(freeze_o), .mf_pulse_o(mf_pulse_o)
    );

    int n_cmp = 0, n_bad = 0;
    logic [3:0] tx   [24];
    logic [3:0] expv [24];
    logic [3:0] obs0 [24];
    logic [3:0] obs7 [24];
    int e_bit8, e_chclk, e_mfp, n_mfp;
    logic fz_mid;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] map_sig(input logic [3:0] t, input bit ext);
        return ext ? t : {t[3], t[2], t[3], t[2]};
    endfunction

    function automatic logic sig_bit(input int f, input int ch, input bit ext);
        if (f == 5)         return tx[ch][3];
        if (f == 11)        return tx[ch][2];
        if (ext && f == 17) return tx[ch][1];
        if (ext && f == 23) return tx[ch][0];
        return ch[0];
    endfunction

    task automatic step(input logic s, input logic v, input int ch, input int bt,
                        input int fr, input logic last);
        ser_in = s; bit_vld = v;
        chan_idx = 5'(ch); bit_idx = 3'(bt); frame_idx = 5'(fr);
        @(posedge clk);
        @(negedge clk);
        if (bit8_o !== (v && bt == 7)) e_bit8++;
        if (chan_clk_o !== (v && bt < 4)) e_chclk++;
        if (mf_pulse_o !== last) e_mfp++;
        if (mf_pulse_o === 1'b1) n_mfp++;
        if (v && bt == 0) obs0[ch] = {sig_a, sig_b, sig_c, sig_d};
        if (v && bt == 7) obs7[ch] = {sig_a, sig_b, sig_c, sig_d};
        if (v && fr == 2 && ch == 0 && bt == 0) fz_mid = freeze_o;
    endtask

    task automatic run_mf(input bit ext);
        int nf;
        nf = ext ? 24 : 12;
        e_bit8 = 0; e_chclk = 0; e_mfp = 0; n_mfp = 0;
        ext_mf = ext;
        for (int f = 0; f < nf; f++) begin
            step(1'b0, 1'b0, 0, 0, f, 1'b0);
            for (int ch = 0; ch < 24; ch++)
                for (int bt = 0; bt < 8; bt++)
                    step((bt == 7) ? sig_bit(f, ch, ext) : logic'(((ch + bt + f) % 3) == 0),
                         1'b1, ch, bt, f, (f == nf-1 && ch == 23 && bt == 7));
        end
        check(e_bit8 == 0, "R1", "bit8 strobe misplaced steps", e_bit8, 0);
        check(e_chclk == 0, "R2", "channel clock misplaced steps", e_chclk, 0);
        check(e_mfp == 0 && n_mfp == 1, "R9", "multiframe pulses", n_mfp, 1);
    endtask

    task automatic check_held(input string req);
        int bad_ch, act, exp, unst;
        bad_ch = -1; act = 0; exp = 0; unst = 0;
        for (int c = 0; c < 24; c++) begin
            if (obs0[c] !== obs7[c]) unst++;
            if (bad_ch < 0 && obs0[c] !== expv[c]) begin
                bad_ch = c; act = int'(obs0[c]); exp = int'(expv[c]);
            end
        end
        check(bad_ch < 0, req, $sformatf("held ABCD of channel %0d", bad_ch), act, exp);
        check(unst == 0, "R10", "channels changing within their bit time", unst, 0);
    endtask

    task automatic set_exp(input bit ext);
        for (int c = 0; c < 24; c++) expv[c] = map_sig(tx[c], ext);
    endtask

    function automatic logic [3:0] base_v(input int c);
        return 4'((c * 5 + 3) % 16);
    endfunction

    task automatic t_reset;
        check({sig_a, sig_b, sig_c, sig_d, bit8_o, chan_clk_o, freeze_o, mf_pulse_o} == 8'h00,
              "R11", "outputs after reset",
              int'({sig_a, sig_b, sig_c, sig_d, bit8_o, chan_clk_o, freeze_o, mf_pulse_o}), 0);
    endtask

    task automatic t_integrate;
        for (int c = 0; c < 24; c++) tx[c] = base_v(c);
        for (int c = 0; c < 24; c++) expv[c] = 4'h0;
        run_mf(1'b0); check_held("R11");
        run_mf(1'b0); check_held("R5");
        run_mf(1'b0); set_exp(1'b0); check_held("R3");
    endtask

    task automatic t_glitch;
        for (int c = 0; c < 24; c++) expv[c] = map_sig(base_v(c), 1'b0);
        for (int k = 0; k < 4; k++) begin
            for (int c = 0; c < 24; c++)
                tx[c] = base_v(c) ^ ((k % 2 == 0) ? 4'b1000 : 4'b0100);
            run_mf(1'b0); check_held("R5");
        end
    endtask

    task automatic t_slip;
        for (int c = 0; c < 24; c++) tx[c] = base_v(c) ^ 4'b1100;
        run_mf(1'b0); check_held("R6");
        slip_in = 1'b1;
        run_mf(1'b0); check_held("R6");
        check(fz_mid == 1'b1, "R6", "freeze during slip", int'(fz_mid), 1);
        slip_in = 1'b0;
        run_mf(1'b0); check_held("R6");
        run_mf(1'b0); set_exp(1'b0); check_held("R6");
    endtask

    task automatic t_inhibit;
        for (int c = 0; c < 24; c++) tx[c] = base_v(c) ^ 4'b1000;
        hold_mode = 2'b10;
        inhibit_n = 1'b0;
        run_mf(1'b0); check_held("R7");
        check(fz_mid == 1'b1, "R7", "freeze while inhibited", int'(fz_mid), 1);
        inhibit_n = 1'b1;
        run_mf(1'b0); check_held("R8");
        check(fz_mid == 1'b1, "R8", "freeze first timed multiframe", int'(fz_mid), 1);
        run_mf(1'b0); check_held("R8");
        check(fz_mid == 1'b1, "R8", "freeze second timed multiframe", int'(fz_mid), 1);
        run_mf(1'b0); check_held("R8");
        check(fz_mid == 1'b0, "R8", "freeze after timed hold", int'(fz_mid), 0);
        run_mf(1'b0); set_exp(1'b0); check_held("R8");
    endtask

    task automatic t_extended;
        for (int c = 0; c < 24; c++) tx[c] = 4'((c * 7 + 9) % 16);
        run_mf(1'b1);
        run_mf(1'b1); check_held("R5");
        run_mf(1'b1); set_exp(1'b1); check_held("R4");
    endtask

    bit done = 1'b0;

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_integrate();
        t_glitch();
        t_slip();
        t_inhibit();
        t_extended();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule